// File: doc/BRIEF.md
# Graphics Engine Interrupt Aggregator

This block collects one-cycle event pulses from three sources inside a graphics engine: a render frame has finished, the binning stage has flushed, and the binner has run out of memory. Each pulse sets a sticky pending bit. Software reads the pending bits through a small register port and clears them by writing ones.

Each source can raise the interrupt line only when its enable bit is set. The enable mask has no direct write path. Software changes it through two registers: writing ones to the first register turns bits on, and writing ones to the second register turns bits off. Zero bits have no effect in either register. Both registers read back the same current mask. The single interrupt line is a registered level. It stays high while any enabled source is pending.

The register port has an address, a write strobe, write data and read data. Read data is registered. It appears in the cycle after the address is presented. Each register holds one bit per source in its low bits, and the remaining bits read as zero.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit and every enable bit is zero, and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets pending bit k whether or not source k is enabled. The bit reads as 1 at offset 0x0 from then on. Bit 0 is render frame done, bit 1 is binning flush done, and bit 2 is binner out of memory.
- R3: A write to offset 0x0 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 are left unchanged.
- R4: When a new pulse on `evt_i[k]` arrives in the same cycle as a write that clears pending bit k, the bit stays set.
- R5: A write to offset 0x4 sets each enable bit whose write-data bit is 1. Zero bits leave the enable bits unchanged.
- R6: A write to offset 0x8 clears each enable bit whose write-data bit is 1. Zero bits leave the enable bits unchanged.
- R7: A read of offset 0x4 and a read of offset 0x8 both return the current enable mask in bits [2:0]. The write-data bits above bit 2 have no effect, and the read-data bits above bit 2 are zero.
- R8: `irq_o` equals the OR over all sources of (pending AND enabled), delayed by one cycle. Enabling a source that is already pending therefore raises `irq_o` one cycle after the enable bit is set.
- R9: `reg_rdata_o` is registered. After a clock edge it shows the register selected by `reg_addr_i` as it stood before any write made at that same edge.
- R10: Any offset other than 0x0, 0x4 or 0x8 reads as zero. A write to such an offset changes neither the pending bits nor the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | N_SRC | One-cycle event pulses (bit 0 render done, bit 1 bin flush done, bit 2 binner out of memory) |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets a pulse that lands in the same cycle as a clear of the same bit. A design that gives priority to the clear would lose that event, so the pending bit would read 0. The bench checks that zero bits in the set and clear writes leave the enable mask alone. A design that loads the mask directly from the write data would drop enables the write did not name. The bench enables a source that is already pending and checks that the interrupt rises one cycle later; a design that only reacts to new edges would never raise it. Reads of unmapped offsets, reads of the upper data bits, and a read made in the same cycle as a write are also compared. These catch leaked upper bits, aliasing of unmapped offsets onto real registers, and read data that is off by one cycle.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned OFF_PEND  = 32'h0;
  localparam int unsigned OFF_ENSET = 32'h4;
  localparam int unsigned OFF_ENCLR = 32'h8;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_ENSET = 2'd1,
    SEL_ENCLR = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
`timescale 1ns/1ps
module irq_addr_decode #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output irq_pkg::reg_sel_e sel_o,
  output logic              pend_wr_o,
  output logic              enset_wr_o,
  output logic              enclr_wr_o
);
  import irq_pkg::*;

  always_comb begin
    if (addr_i == ADDR_W'(OFF_PEND))       sel_o = SEL_PEND;
    else if (addr_i == ADDR_W'(OFF_ENSET)) sel_o = SEL_ENSET;
    else if (addr_i == ADDR_W'(OFF_ENCLR)) sel_o = SEL_ENCLR;
    else                                   sel_o = SEL_NONE;
  end

  assign pend_wr_o  = wr_i && (sel_o == SEL_PEND);
  assign enset_wr_o = wr_i && (sel_o == SEL_ENSET);
  assign enclr_wr_o = wr_i && (sel_o == SEL_ENCLR);
endmodule

// File: rtl/irq_pending_reg.sv
`timescale 1ns/1ps
module irq_pending_reg #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_wr_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  output logic [N_SRC-1:0] pend_q
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        pend_q[k] <= 1'b0;
      else if (evt_i[k])
        pend_q[k] <= 1'b1;   // a new event outranks a same-cycle clear
      else if (clr_wr_i && clr_mask_i[k])
        pend_q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_wr_i,
  input  logic             clr_wr_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] en_q
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        en_q[k] <= 1'b0;
      else if (set_wr_i && mask_i[k])
        en_q[k] <= 1'b1;
      else if (clr_wr_i && mask_i[k])
        en_q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/gfx_irq_ctrl.sv
`timescale 1ns/1ps
module gfx_irq_ctrl #(
  parameter int N_SRC  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  import irq_pkg::*;

  localparam int PAD_W = DATA_W - N_SRC;

  reg_sel_e         sel;
  logic             pend_wr, enset_wr, enclr_wr;
  logic [N_SRC-1:0] wmask;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] rsel;
  logic             unused_wdata_hi;

  assign wmask           = reg_wdata_i[N_SRC-1:0];
  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:N_SRC];

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .sel_o      (sel),
    .pend_wr_o  (pend_wr),
    .enset_wr_o (enset_wr),
    .enclr_wr_o (enclr_wr)
  );

  irq_pending_reg #(.N_SRC(N_SRC)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .clr_wr_i   (pend_wr),
    .clr_mask_i (wmask),
    .pend_q     (status_q)
  );

  irq_enable_reg #(.N_SRC(N_SRC)) u_en (
    .clk      (clk),
    .rst      (rst),
    .set_wr_i (enset_wr),
    .clr_wr_i (enclr_wr),
    .mask_i   (wmask),
    .en_q     (enable_q)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND:             rsel = status_q;
      SEL_ENSET, SEL_ENCLR: rsel = enable_q;
      default:              rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      reg_rdata_o <= {{PAD_W{1'b0}}, rsel};
      irq_o       <= |(status_q & enable_q);
    end
  end
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_chk #(
  parameter int N_SRC  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  evt_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q
);
  logic wr_pend, wr_set, wr_clr;
  assign wr_pend = reg_wr_i && (reg_addr_i == ADDR_W'(irq_pkg::OFF_PEND));
  assign wr_set  = reg_wr_i && (reg_addr_i == ADDR_W'(irq_pkg::OFF_ENSET));
  assign wr_clr  = reg_wr_i && (reg_addr_i == ADDR_W'(irq_pkg::OFF_ENCLR));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (status_q == '0 && enable_q == '0 && !irq_o && reg_rdata_o == '0));

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assert_evt_latch_R2: assert property (@(posedge clk) disable iff (rst)
      evt_i[k] |=> status_q[k]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_pend && reg_wdata_i[k] && !evt_i[k]) |=> !status_q[k]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!evt_i[k] && !(wr_pend && reg_wdata_i[k])) |=> $stable(status_q[k]));
    assert_en_set_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_set && reg_wdata_i[k]) |=> enable_q[k]);
    assert_en_clr_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_clr && reg_wdata_i[k]) |=> !enable_q[k]);
    assert_en_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !((wr_set || wr_clr) && reg_wdata_i[k]) |=> $stable(enable_q[k]));
  end

  assert_irq_high_R8: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & enable_q)) |=> irq_o);
  assert_irq_low_R8: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & enable_q)) |=> !irq_o);
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    reg_rdata_o[DATA_W-1:N_SRC] == '0);
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt_i       (evt_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .status_q    (status_q),
  .enable_q    (enable_q)
);

// File: tb/gfx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_tb;
  localparam int N  = 3;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  evt = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  logic [N-1:0]  m_st = '0, m_en = '0;
  logic          m_irq = 1'b0;
  logic [DW-1:0] m_rd = '0;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  gfx_irq_ctrl #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [DW-1:0] rd_model(logic [AW-1:0] a, logic [N-1:0] st, logic [N-1:0] en);
    case (a)
      AW'(0):       return DW'(st);
      AW'(4), AW'(8): return DW'(en);
      default:      return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] st_model(logic [N-1:0] st, logic [N-1:0] e, logic w,
                                            logic [AW-1:0] a, logic [DW-1:0] d);
    logic [N-1:0] clr;
    clr = (w && a == AW'(0)) ? d[N-1:0] : '0;
    return (st & ~clr) | e;
  endfunction

  function automatic logic [N-1:0] en_model(logic [N-1:0] en, logic w,
                                            logic [AW-1:0] a, logic [DW-1:0] d);
    if (w && a == AW'(4)) return en | d[N-1:0];
    if (w && a == AW'(8)) return en & ~d[N-1:0];
    return en;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic [N-1:0] e, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [N-1:0] nst, nen;
    @(negedge clk);
    evt = e; wr = w; addr = a; wdata = d;
    m_rd  = rd_model(a, m_st, m_en);
    m_irq = |(m_st & m_en);
    nst = st_model(m_st, e, w, a, d);
    nen = en_model(m_en, w, a, d);
    @(posedge clk); #1;
    m_st = nst; m_en = nen;
    chk(tag, rdata, m_rd);
    chk({tag, " R8 irq"}, DW'(irq), DW'(m_irq));
  endtask

  function automatic string tag_for(logic [AW-1:0] a);
    case (a)
      AW'(0): return "R3 status";
      AW'(4): return "R5 enset";
      AW'(8): return "R7 enclr";
      default: return "R10 unmapped";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    cyc("R1 status", '0, 0, AW'(0), '0);
    cyc("R1 enable", '0, 0, AW'(4), '0);
    // R2: events latch while disabled
    cyc("R2 pulse", 3'b101, 0, AW'(0), '0);
    cyc("R2 read", '0, 0, AW'(0), '0);
    chk("R2 pending", rdata, 32'h5);
    // R3: write one clears, zero keeps
    cyc("R3 clear", '0, 1, AW'(0), 32'h1);
    cyc("R3 read", '0, 0, AW'(0), '0);
    chk("R3 pending", rdata, 32'h4);
    // R4: event beats clear
    cyc("R4 collide", 3'b100, 1, AW'(0), 32'h4);
    cyc("R4 read", '0, 0, AW'(0), '0);
    chk("R4 pending", rdata, 32'h4);
    // R5: set enables, zero bits ignored; R8 pending source raises irq
    cyc("R5 set", '0, 1, AW'(4), 32'h1);
    cyc("R5 read", '0, 0, AW'(4), '0);
    chk("R5 mask", rdata, 32'h1);
    cyc("R5 set2", '0, 1, AW'(4), 32'h6);
    cyc("R8 wait", '0, 0, AW'(0), '0);
    chk("R8 pending enabled", DW'(irq), 32'h1);
    // R7: upper write bits ignored, both offsets read mask
    cyc("R7 upper", '0, 1, AW'(8), 32'hFFFF_FFF8);
    cyc("R7 rd4", '0, 0, AW'(4), '0);
    chk("R7 mask4", rdata, 32'h7);
    cyc("R7 rd8", '0, 0, AW'(8), '0);
    chk("R7 mask8", rdata, 32'h7);
    // R6: disable bit 2, others kept
    cyc("R6 clr", '0, 1, AW'(8), 32'h4);
    cyc("R6 read", '0, 0, AW'(8), '0);
    chk("R6 mask", rdata, 32'h3);
    cyc("R6 irq", '0, 0, AW'(0), '0);
    chk("R6 irq low", DW'(irq), 32'h0);
    // R10: unmapped offset
    cyc("R10 wr", '0, 1, AW'(12), 32'hFFFF_FFFF);
    cyc("R10 rd", '0, 0, AW'(12), '0);
    chk("R10 zero", rdata, 32'h0);
    cyc("R10 en", '0, 0, AW'(4), '0);
    chk("R10 en kept", rdata, 32'h3);
    // R9: read in same cycle as write shows old value
    cyc("R9 rw", 3'b001, 0, AW'(0), '0);
    cyc("R9 same", '0, 1, AW'(0), 32'h7);
    chk("R9 old value", rdata, 32'h5);
    // random traffic
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0]  e;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      e = '0;
      for (int k = 0; k < N; k++) e[k] = ($urandom % 5) == 0;
      case ($urandom % 5)
        0: a = AW'(0);
        1: a = AW'(4);
        2: a = AW'(8);
        3: a = AW'(12);
        default: a = AW'($urandom);
      endcase
      d = $urandom;
      cyc(tag_for(a), e, ($urandom % 2) == 1, a, d);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule